// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a clocked on-chip request port and an external asynchronous static RAM of 256K words by 16 bits. It accepts one read or one write at a time and turns it into a timed pin sequence. The sequence covers the address, the active-low chip select, the write strobe, the output enable, the two byte-lane enables and a 16-bit data bus. The data bus is split into separate in, out and drive-enable signals. Every phase lasts a whole number of clock cycles. These counts are worked out at elaboration from the clock period and the RAM's nanosecond minimums, so one parameter change retargets the block to another clock.

The request port is valid/ready. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle, so a requester must hold its request and its fields stable until that edge. A read returns its word on a one-cycle `rsp_valid` pulse. The response path has no back-pressure, so the requester must accept it on that cycle. Writes return nothing.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, chip select, write strobe, output enable and both lane enables are high (inactive), the data bus is not driven and `rsp_valid` is low.
- R2: A read drives both lane enables low and returns the full 16-bit word last stored at that address on a `rsp_valid` pulse lasting exactly one cycle.
- R3: A write with `req_be` = 2'b11 stores the whole word. `req_be[0]` selects bits 7:0 (lower lane pin `sram_lb_n`) and `req_be[1]` selects bits 15:8 (upper lane pin `sram_ub_n`).
- R4: A write with exactly one `req_be` bit set changes only that byte, and the other byte keeps its old value.
- R5: A write with `req_be` = 2'b00 is accepted in one cycle and causes no pin activity: `req_ready` and `sram_ce_n` stay high on the following cycle, and memory is unchanged.
- R6: Read data is sampled RD cycles after the accepting edge, where RD is the larger of ceil(45 ns / period) and the cycles needed to make the whole read cycle at least 45 ns. `rsp_valid` is high in the cycle after the sampling edge. RD is 5 at the default 10 ns period.
- R7: `req_ready` returns high RD+TA cycles after a read is accepted, and SU+PW+1 cycles after a non-empty write is accepted. At a 10 ns period, TA=2, SU=1 and PW=4.
- R8: In a write, the bus is driven and chip select is low for SU+PW cycles. The write strobe is low for the last PW cycles of that window, with output enable high and the address constant. The bus stays driven for one more cycle after the strobe rises.
- R9: In a read, output enable is low for RD cycles and the data bus is never driven while output enable is low.
- R10: The bus is driven no sooner than TA cycles (ceil(18 ns / period)) after output enable rises. Every strobe is at least 35 ns wide, and the data settles at least 25 ns before the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane mask for writes, bit 0 = bits 7:0 |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read word |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_lb_n | output | 1 | Lower lane enable, active low |
| sram_ub_n | output | 1 | Upper lane enable, active low |
| sram_dq_out | output | 16 | Data driven to RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 16 | Data returned by RAM |

## Verification
The assertions assume the requester keeps `req_valid` and its fields steady until accepted, and that reset is held for at least one edge. The directed tasks drive each request at a falling edge and leave it in place until `req_ready` is seen. The RAM model in the bench returns a poison value until 45 ns after its address and enables settle. Any early sample therefore reaches the scoreboard as a wrong word rather than being hidden by a cycle-accurate model.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_RECOVER
  } seq_state_e;

  // Whole clock cycles that cover a nanosecond minimum.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 5,
  parameter int SU_CYC = 1,
  parameter int PW_CYC = 4,
  parameter int TA_CYC = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic             tmr_expired,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic [LANES-1:0] lane_n
);

  seq_state_e       state_q, state_d;
  logic             is_wr_q;
  logic [LANES-1:0] lane_q, lane_d;
  logic             active_d;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !req_write) begin
          state_d  = ST_RD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RD_CYC - 1);
          accept   = 1'b1;
        end else if (req_valid && (|req_be)) begin
          state_d  = ST_WR_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SU_CYC - 1);
          accept   = 1'b1;
        end
      end
      ST_RD_WAIT: if (tmr_expired) begin
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TA_CYC - 1);
        capture  = 1'b1;
      end
      ST_WR_SETUP: if (tmr_expired) begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PW_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_expired) begin
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = '0;
      end
      ST_RECOVER: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Reads open both lanes; writes use the request mask.
  assign lane_d   = accept ? (req_write ? req_be : '1) : lane_q;
  assign active_d = (state_d == ST_RD_WAIT) || (state_d == ST_WR_SETUP) ||
                    (state_d == ST_WR_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      lane_q  <= '0;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      lane_n  <= '1;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      if (accept) is_wr_q <= req_write;
      // Pins follow the next state, so they leave a flop with no decode glitch.
      ce_n    <= !active_d;
      oe_n    <= !(state_d == ST_RD_WAIT);
      we_n    <= !(state_d == ST_WR_PULSE);
      dq_oe   <= (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                 ((state_d == ST_RECOVER) && is_wr_q);
      lane_n  <= active_d ? ~lane_d : '1;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 45,
  parameter int T_AA_NS   = 45,
  parameter int T_DOE_NS  = 22,
  parameter int T_WC_NS   = 45,
  parameter int T_PWE_NS  = 35,
  parameter int T_SD_NS   = 25,
  parameter int T_HZOE_NS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int LANES  = DATA_W / 8;
  localparam int TA_CYC = imax(1, ns_to_cyc(T_HZOE_NS, CLK_NS));
  localparam int RD_CYC = imax(imax(1, ns_to_cyc(T_AA_NS, CLK_NS)),
                               imax(ns_to_cyc(T_DOE_NS, CLK_NS),
                                    ns_to_cyc(T_RC_NS, CLK_NS) - TA_CYC - 1));
  localparam int PW_CYC = imax(1, ns_to_cyc(T_PWE_NS, CLK_NS));
  localparam int SU_CYC = imax(1, imax(ns_to_cyc(T_WC_NS, CLK_NS) - PW_CYC - 1,
                                       ns_to_cyc(T_SD_NS, CLK_NS) - PW_CYC));
  localparam int MAX_CYC = imax(imax(RD_CYC, TA_CYC), imax(PW_CYC, SU_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, capture, tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic [LANES-1:0] lane_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .SU_CYC (SU_CYC),
    .PW_CYC (PW_CYC),
    .TA_CYC (TA_CYC),
    .LANES  (LANES)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_be      (req_be[LANES-1:0]),
    .tmr_expired (tmr_expired),
    .req_ready   (req_ready),
    .accept      (accept),
    .capture     (capture),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .ce_n        (sram_ce_n),
    .we_n        (sram_we_n),
    .oe_n        (sram_oe_n),
    .dq_oe       (sram_dq_oe),
    .lane_n      (lane_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // One capture register per byte lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q[g*8 +: 8] <= '0;
      else if (capture) rdata_q[g*8 +: 8] <= sram_dq_in[g*8 +: 8];
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign sram_lb_n   = lane_n[0];
  assign sram_ub_n   = lane_n[LANES-1];
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int CLK_NS    = 10,
  parameter int T_HZOE_NS = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_be,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_lb_n,
  input logic              sram_ub_n,
  input logic              sram_dq_oe
);

  localparam int GAP_CYC = imax(1, ns_to_cyc(T_HZOE_NS, CLK_NS));

  logic [3:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               oe_hi_cnt <= 4'hF;
    else if (!sram_oe_n)      oe_hi_cnt <= '0;
    else if (oe_hi_cnt != 4'hF) oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (req_be == 2'b00)) |=> (sram_ce_n && req_ready));

  // R7
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> !req_ready);

  // R8
  strobe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_dq_oe && sram_oe_n));

  // R8
  data_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  // R8
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

  // R9
  read_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_dq_oe && sram_we_n && !sram_lb_n && !sram_ub_n));

  // R10
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (int'(oe_hi_cnt) >= GAP_CYC));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_be     (req_be),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_lb_n  (sram_lb_n),
  .sram_ub_n  (sram_ub_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam real HALF = CLK_PERIOD / 2.0;
  localparam int EXP_RD = 5;
  localparam int EXP_TA = 2;
  localparam int EXP_SU = 1;
  localparam int EXP_PW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = 2'b00;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
  logic [15:0] sram_dq_out;
  logic [15:0] ram_dq = 16'hDEAD;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(ram_dq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- RAM model, evaluated mid-cycle ----------------
  logic [15:0] mdl_mem [int];
  logic [15:0] sb      [int];
  realtime last_edge = 0, wr_start = 0, dq_chg_t = 0, addr_chg_t = 0, rd_t0 = 0, oe_rise_t = -1000;
  logic [17:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  logic p_ce = 1, p_we = 1, p_oe = 1, p_lb = 1, p_ub = 1, p_dqoe = 0, p_wact = 0;

  function automatic logic [15:0] mdl_rd(input int a);
    return mdl_mem.exists(a) ? mdl_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] sb_rd(input int a);
    return sb.exists(a) ? sb[a] : 16'h0000;
  endfunction

  always @(posedge clk) last_edge = $realtime;

  always @(negedge clk) begin
    logic wact;
    logic [15:0] v;
    wact = !sram_ce_n && !sram_we_n && (!sram_lb_n || !sram_ub_n);
    if (wact && !p_wact) wr_start = last_edge;
    if (p_wact && !wact) begin
      // R10 strobe width and data setup; R8 data held and address stable
      chk((last_edge - wr_start) >= 35.0, "R10 strobe width ns", 32'(int'(last_edge - wr_start)), 35);
      chk((last_edge - dq_chg_t) >= 25.0, "R10 data setup ns", 32'(int'(last_edge - dq_chg_t)), 25);
      chk(p_dqoe, "R8 bus driven at strobe end", 32'(p_dqoe), 1);
      chk(addr_chg_t <= wr_start, "R8 address stable in write", 32'(int'(addr_chg_t)), 32'(int'(wr_start)));
      v = mdl_rd(int'(p_addr));
      if (!p_lb) v[7:0]  = p_dq[7:0];
      if (!p_ub) v[15:8] = p_dq[15:8];
      mdl_mem[int'(p_addr)] = v;
    end
    if (sram_dq_out != p_dq || sram_dq_oe != p_dqoe) dq_chg_t = last_edge;
    if (sram_addr != p_addr) addr_chg_t = last_edge;
    if (sram_oe_n && !p_oe) oe_rise_t = last_edge;
    if (sram_dq_oe && !p_dqoe)
      chk((last_edge - oe_rise_t) >= 18.0, "R10 turnaround ns", 32'(int'(last_edge - oe_rise_t)), 18);
    if (sram_dq_oe && !sram_oe_n && !sram_ce_n)
      chk(1'b0, "R9 bus contention", 1, 0);
    if (sram_addr != p_addr || sram_ce_n != p_ce || sram_oe_n != p_oe ||
        sram_lb_n != p_lb || sram_ub_n != p_ub) rd_t0 = last_edge;
    if (!sram_ce_n && !sram_oe_n && sram_we_n && ($realtime + HALF - rd_t0) >= 45.0) begin
      v = mdl_rd(int'(sram_addr));
      ram_dq = {sram_ub_n ? 8'hDE : v[15:8], sram_lb_n ? 8'hAD : v[7:0]};
    end else begin
      ram_dq = 16'hDEAD;
    end
    p_addr = sram_addr; p_dq = sram_dq_out; p_ce = sram_ce_n; p_we = sram_we_n;
    p_oe = sram_oe_n; p_lb = sram_lb_n; p_ub = sram_ub_n; p_dqoe = sram_dq_oe; p_wact = wact;
  end

  // ---------------- one transfer, caller stands at a falling edge ----------------
  task automatic op(input bit wr, input logic [1:0] be, input logic [17:0] a, input logic [15:0] d);
    int c = 0, rsp_at = -1, n_rsp = 0, we_lo = 0, ce_lo = 0, oe_lo = 0, dqo = 0;
    logic [15:0] got = '0;
    logic [15:0] exp;
    logic ce_first;
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ce_first = sram_ce_n;
    while (!req_ready && c < 100) begin
      if (!sram_we_n) we_lo++;
      if (!sram_ce_n) ce_lo++;
      if (!sram_oe_n) oe_lo++;
      if (sram_dq_oe) dqo++;
      if (rsp_valid) begin n_rsp++; rsp_at = c; got = rsp_rdata; end
      @(negedge clk);
      c++;
    end
    if (rsp_valid) n_rsp++;
    if (!wr) begin
      exp = sb_rd(int'(a));
      chk(got == exp, "R2 read data", 32'(got), 32'(exp));
      chk(n_rsp == 1, "R2 single response", 32'(n_rsp), 1);
      chk(rsp_at == EXP_RD, "R6 read latency", 32'(rsp_at), EXP_RD);
      chk(c == EXP_RD + EXP_TA, "R7 read occupancy", 32'(c), EXP_RD + EXP_TA);
      chk(oe_lo == EXP_RD && dqo == 0, "R9 read waveform", 32'({oe_lo[15:0], dqo[15:0]}), 32'(EXP_RD << 16));
    end else if (be == 2'b00) begin
      chk(c == 0 && ce_first, "R5 empty mask idle", 32'({c[15:0], 15'd0, ce_first}), 1);
    end else begin
      chk(c == EXP_SU + EXP_PW + 1, "R7 write occupancy", 32'(c), EXP_SU + EXP_PW + 1);
      chk(we_lo == EXP_PW && ce_lo == EXP_SU + EXP_PW, "R8 strobe and select cycles",
          32'({we_lo[15:0], ce_lo[15:0]}), 32'({16'(EXP_PW), 16'(EXP_SU + EXP_PW)}));
      chk(dqo == EXP_SU + EXP_PW + 1 && oe_lo == 0, "R8 drive window",
          32'({dqo[15:0], oe_lo[15:0]}), 32'((EXP_SU + EXP_PW + 1) << 16));
      chk(n_rsp == 0, "R2 no response on write", 32'(n_rsp), 0);
      exp = sb_rd(int'(a));
      if (be[0]) exp[7:0]  = d[7:0];
      if (be[1]) exp[15:8] = d[15:8];
      sb[int'(a)] = exp;
    end
  endtask

  task automatic t_reset();
    chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n,
        "R1 control pins idle", 32'({sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}), 32'h1F);
    chk(!sram_dq_oe && !rsp_valid && req_ready, "R1 bus idle and ready",
        32'({sram_dq_oe, rsp_valid, req_ready}), 32'h1);
  endtask

  task automatic t_full_word();
    op(1, 2'b11, 18'h00010, 16'h1234);   // R3
    op(0, 2'b00, 18'h00010, 16'h0000);   // R2
    op(0, 2'b11, 18'h00777, 16'h0000);   // R2 unwritten
  endtask

  task automatic t_byte_lanes();
    op(1, 2'b11, 18'h00020, 16'hA5A5);
    op(1, 2'b01, 18'h00020, 16'h1122);   // R4 lower only
    op(0, 2'b00, 18'h00020, 16'h0000);
    chk(rsp_rdata == 16'hA522, "R4 lower lane", 32'(rsp_rdata), 32'hA522);
    op(1, 2'b10, 18'h00020, 16'h3344);   // R4 upper only
    op(0, 2'b00, 18'h00020, 16'h0000);
    chk(rsp_rdata == 16'h3322, "R4 upper lane", 32'(rsp_rdata), 32'h3322);
  endtask

  task automatic t_empty_mask();
    op(1, 2'b11, 18'h00030, 16'hBEEF);
    op(1, 2'b00, 18'h00030, 16'h0000);   // R5
    chk(sram_ce_n && sram_we_n, "R5 no strobe", 32'({sram_ce_n, sram_we_n}), 3);
    op(0, 2'b00, 18'h00030, 16'h0000);
    chk(rsp_rdata == 16'hBEEF, "R5 memory unchanged", 32'(rsp_rdata), 32'hBEEF);
  endtask

  task automatic t_edges();
    op(1, 2'b11, 18'h3FFFF, 16'hFFFF);
    op(1, 2'b11, 18'h00000, 16'h0001);
    op(0, 2'b00, 18'h3FFFF, 16'h0000);   // R2 top address
    op(0, 2'b00, 18'h00000, 16'h0000);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 12; i++) begin
      op(1, 2'b11, 18'(40 + i), 16'(16'h0F00 + i));   // R10 write after read turnaround
      op(0, 2'b00, 18'(40 + i), 16'h0000);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 150; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0], r[2:1], 18'(r[6:3]), r[31:16]);          // R3 R4 scoreboard
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_byte_lanes();
    t_empty_mask();
    t_edges();
    t_back_to_back();
    t_random();
    repeat (3) @(negedge clk);
    t_reset();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule